// File: doc/BRIEF.md
# Blowfish Block Cipher Round Engine

This engine turns one 64-bit block into its Blowfish ciphertext, or back into plaintext, with a sixteen-round Feistel network. The block is split into an upper half XL and a lower half XR. Each round mixes a P-array entry into XL. It then folds the round function of XL into XR and exchanges the halves. After the last round the exchange is taken back, and both halves are whitened with the two remaining P-array entries.

The four substitution boxes (S1 to S4, each 256 x 32 bits) and the eighteen-word P-array live inside the engine. They are filled through a table write port while the engine is idle. The P-array is split across two kinds of storage. Its two outer words, P1 and P18, are flip-flops. The sixteen inner words sit in a 16-word RAM. Every table read goes through a register, so a round takes two clock cycles: one to mix and address, one to combine and swap.

A caller loads the tables, then pulses `start` with the block on `blk_in` and the direction on `dir_dec`. The result appears on `blk_out` together with a one-cycle `done` pulse, a fixed number of cycles later.

Top module: `bfish_engine`

## Requirements
- R1: Encryption treats `blk_in[63:32]` as XL and `blk_in[31:0]` as XR. For round i = 1..16 it sets XL ^= P[i], then XR ^= F(XL), then swaps the halves. After round 16 the swap is undone, XR ^= P17 and XL ^= P18, and `blk_out` = {XL, XR}.
- R2: F(x) = ((S1[x[31:24]] + S2[x[23:16]]) ^ S3[x[15:8]]) + S4[x[7:0]], with both additions modulo 2^32.
- R3: With `dir_dec` = 1 the same network uses P18 down to P3 in rounds 1..16, then XORs XR with P2 and XL with P1. Decrypting an encrypted block returns the original block.
- R4: A write with `wr_en` = 1 and `wr_to_p` = 1 stores `wr_data` into P[`wr_index`+1] when `wr_index` is 0..17. Any larger index changes nothing. With `wr_to_p` = 0 it stores into S-box `wr_box`+1 (0 = S1 .. 3 = S4) at entry `wr_index`.
- R5: Table writes are ignored while a block is in progress. They are also ignored in the cycle in which a start is accepted.
- R6: `done` rises in the cycle after the 34th rising clock edge that follows the edge that accepted `start`.
- R7: `done` is high for exactly one cycle per block.
- R8: `blk_out` changes only in a cycle where `done` is high and holds its value at all other times.
- R9: A `start` pulse while a block is in progress is ignored. The current block finishes with unchanged timing and result.
- R10: After synchronous reset `done` is 0, `blk_out` is 0, and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing `blk_in` when idle |
| dir_dec | input | 1 | 0 = encrypt, 1 = decrypt; sampled with `start` |
| blk_in | input | 64 | Input block, XL in the upper half |
| wr_en | input | 1 | Table write strobe |
| wr_to_p | input | 1 | 1 = write the P-array, 0 = write an S-box |
| wr_box | input | 2 | S-box select, 0..3 for S1..S4 |
| wr_index | input | 8 | Entry index within the selected table |
| wr_data | input | 32 | Word to be written |
| blk_out | output | 64 | Result block, held until the next result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume that reset is held for at least two clock edges before the first start. They also assume that table contents are defined before any block is started, since the memories themselves have no reset. The bench holds reset for five cycles and loads every S-box entry and every P-array word before its first start. It drives table writes and starts from the falling clock edge, and it deliberately places writes and extra starts inside busy windows to reach the cases the engine must ignore.

// File: rtl/bfish_pkg.sv
package bfish_pkg;

    localparam int HALF_W   = 32;
    localparam int BLK_W    = 2 * HALF_W;
    localparam int ROUNDS   = 16;
    localparam int P_NUM    = ROUNDS + 2;
    localparam int SBOX_N   = 4;
    localparam int SBOX_D   = 256;
    localparam int IDX_W    = $clog2(SBOX_D);
    localparam int BOX_W    = $clog2(SBOX_N);
    localparam int P_IDX_W  = $clog2(P_NUM);
    localparam int LATENCY  = 2 * ROUNDS + 2;

    typedef logic [HALF_W-1:0] word_t;

    typedef struct packed {
        word_t l;
        word_t r;
    } blk_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIX,
        ST_FEED,
        ST_WHT_R,
        ST_WHT_L
    } eng_state_e;

    // Map a schedule step (0..P_NUM-1) to a P-array slot for the chosen direction.
    function automatic logic [P_IDX_W-1:0] p_step_index(input logic dec,
                                                        input logic [P_IDX_W-1:0] step);
        return dec ? (P_IDX_W'(P_NUM - 1) - step) : step;
    endfunction

endpackage

// File: rtl/bfish_parray.sv
module bfish_parray
    import bfish_pkg::*;
#(
    parameter int NUM = P_NUM,
    parameter int W   = HALF_W,
    parameter int IW  = IDX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(NUM)-1:0]   rd_idx,
    output logic [W-1:0]             rd_data
);
    localparam int RIW    = $clog2(NUM);
    localparam int MID_N  = NUM - 2;
    localparam int MID_AW = $clog2(MID_N);

    logic [W-1:0] first_q;
    logic [W-1:0] last_q;
    logic [W-1:0] mid_q [MID_N];

    logic wr_ok;
    logic wr_first;
    logic wr_last;
    logic [MID_AW-1:0] wr_mid_a;
    logic [MID_AW-1:0] rd_mid_a;

    assign wr_ok    = wr_en && (wr_idx < IW'(NUM));
    assign wr_first = wr_ok && (wr_idx == '0);
    assign wr_last  = wr_ok && (wr_idx == IW'(NUM - 1));
    assign wr_mid_a = MID_AW'(wr_idx - IW'(1));
    assign rd_mid_a = MID_AW'(rd_idx - RIW'(1));

    // Outer words in flip-flops
    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            last_q  <= '0;
        end else begin
            if (wr_first) first_q <= wr_data;
            if (wr_last)  last_q  <= wr_data;
        end
    end

    // Inner sixteen words in RAM
    always_ff @(posedge clk) begin
        if (wr_ok && !wr_first && !wr_last) mid_q[wr_mid_a] <= wr_data;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_idx == '0) begin
            rd_data <= first_q;
        end else if (rd_idx == RIW'(NUM - 1)) begin
            rd_data <= last_q;
        end else if (rd_idx < RIW'(NUM - 1)) begin
            rd_data <= mid_q[rd_mid_a];
        end else begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/bfish_sbox_bank.sv
module bfish_sbox_bank
    import bfish_pkg::*;
#(
    parameter int N     = SBOX_N,
    parameter int DEPTH = SBOX_D,
    parameter int W     = HALF_W
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(N)-1:0]          wr_box,
    input  logic [$clog2(DEPTH)-1:0]      wr_idx,
    input  logic [W-1:0]                  wr_data,
    input  logic [N*$clog2(DEPTH)-1:0]    rd_key,
    output logic [N-1:0][W-1:0]           rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = $clog2(N);

    for (genvar g = 0; g < N; g++) begin : g_box
        logic [W-1:0]  mem [DEPTH];
        logic [AW-1:0] rd_a;

        // Box 0 takes the most significant slice of the key
        assign rd_a = rd_key[(N-1-g)*AW +: AW];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_box == BW'(g))) mem[wr_idx] <= wr_data;
            rd_data[g] <= mem[rd_a];
        end
    end

endmodule

// File: rtl/bfish_ffunc.sv
module bfish_ffunc
    import bfish_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic [SBOX_N-1:0][W-1:0] s_word,
    output logic [W-1:0]             f_out
);
    logic [W-1:0] sum01;
    logic [W-1:0] mix2;

    assign sum01 = s_word[0] + s_word[1];
    assign mix2  = sum01 ^ s_word[2];
    assign f_out = mix2 + s_word[3];

endmodule

// File: rtl/bfish_engine.sv
module bfish_engine
    import bfish_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                dir_dec,
    input  logic [BLK_W-1:0]    blk_in,
    input  logic                wr_en,
    input  logic                wr_to_p,
    input  logic [BOX_W-1:0]    wr_box,
    input  logic [IDX_W-1:0]    wr_index,
    input  logic [HALF_W-1:0]   wr_data,
    output logic [BLK_W-1:0]    blk_out,
    output logic                done
);
    eng_state_e           st_q;
    logic                 dec_q;
    logic [P_IDX_W-1:0]   step_q;
    blk_t                 blk_q;
    logic [BLK_W-1:0]     out_q;
    logic                 done_q;

    logic                 busy;
    logic                 accept;
    logic                 tbl_ok;
    logic                 last_round;
    logic [P_IDX_W-1:0]   rd_step;
    logic                 rd_dec;
    logic [P_IDX_W-1:0]   p_rd_idx;
    word_t                p_word;
    word_t                mix_l;
    word_t                f_word;
    word_t                new_r;
    logic [SBOX_N-1:0][HALF_W-1:0] s_words;

    assign busy       = (st_q != ST_IDLE);
    assign accept     = start && !busy;
    assign tbl_ok     = wr_en && !busy && !start;
    assign last_round = (step_q == P_IDX_W'(ROUNDS - 1));

    // P read schedule: step 0 on accept, next step from any busy state
    assign rd_step  = busy ? (step_q + P_IDX_W'(1)) : '0;
    assign rd_dec   = busy ? dec_q : dir_dec;
    assign p_rd_idx = p_step_index(rd_dec, rd_step);

    assign mix_l = blk_q.l ^ p_word;
    assign new_r = blk_q.r ^ f_word;

    bfish_parray #(
        .NUM (P_NUM),
        .W   (HALF_W),
        .IW  (IDX_W)
    ) u_parr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_ok && wr_to_p),
        .wr_idx  (wr_index),
        .wr_data (wr_data),
        .rd_idx  (p_rd_idx),
        .rd_data (p_word)
    );

    bfish_sbox_bank #(
        .N     (SBOX_N),
        .DEPTH (SBOX_D),
        .W     (HALF_W)
    ) u_sbox (
        .clk     (clk),
        .wr_en   (tbl_ok && !wr_to_p),
        .wr_box  (wr_box),
        .wr_idx  (wr_index),
        .wr_data (wr_data),
        .rd_key  (mix_l),
        .rd_data (s_words)
    );

    bfish_ffunc #(
        .W (HALF_W)
    ) u_ffunc (
        .s_word (s_words),
        .f_out  (f_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            dec_q  <= 1'b0;
            step_q <= '0;
            blk_q  <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        blk_q  <= blk_t'(blk_in);
                        dec_q  <= dir_dec;
                        step_q <= '0;
                        st_q   <= ST_MIX;
                    end
                end
                ST_MIX: begin
                    blk_q.l <= mix_l;
                    st_q    <= ST_FEED;
                end
                ST_FEED: begin
                    if (last_round) begin
                        blk_q.r <= new_r;
                        st_q    <= ST_WHT_R;
                    end else begin
                        blk_q.l <= new_r;
                        blk_q.r <= blk_q.l;
                        st_q    <= ST_MIX;
                    end
                    step_q <= step_q + P_IDX_W'(1);
                end
                ST_WHT_R: begin
                    blk_q.r <= blk_q.r ^ p_word;
                    step_q  <= step_q + P_IDX_W'(1);
                    st_q    <= ST_WHT_L;
                end
                ST_WHT_L: begin
                    out_q  <= {blk_q.l ^ p_word, blk_q.r};
                    done_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign blk_out = out_q;
    assign done    = done_q;

endmodule

// File: rtl/bfish_engine_chk.sv
module bfish_engine_chk
    import bfish_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [BLK_W-1:0]     blk_out,
    input logic [P_IDX_W-1:0]   step,
    input logic [HALF_W-1:0]    p_lo,
    input logic [HALF_W-1:0]    p_hi
);
    localparam int CW = $clog2(LATENCY + 2);

    logic [CW-1:0] lat_cnt;

    // Cycles since the accepted start, counted independently of the engine
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
        end else if (start && !busy) begin
            lat_cnt <= '0;
        end else if (busy && (lat_cnt < CW'(LATENCY + 1))) begin
            lat_cnt <= lat_cnt + CW'(1);
        end
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(blk_out));

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == CW'(LATENCY)));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && (lat_cnt < CW'(LATENCY - 1))) |=> busy);

    a_r5_p_ends_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(p_lo) && $stable(p_hi)));

    a_r3_step_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step <= P_IDX_W'(P_NUM - 1)));

endmodule

bind bfish_engine bfish_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .blk_out (blk_out),
    .step    (step_q),
    .p_lo    (u_parr.first_q),
    .p_hi    (u_parr.last_q)
);

// File: tb/bfish_engine_bench.sv
module bfish_engine_bench;
    import bfish_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic               dir_dec = 1'b0;
    logic [63:0]        blk_in = '0;
    logic               wr_en = 1'b0;
    logic               wr_to_p = 1'b0;
    logic [1:0]         wr_box = '0;
    logic [7:0]         wr_index = '0;
    logic [31:0]        wr_data = '0;
    logic [63:0]        blk_out;
    logic               done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Behavioural model state
    logic [31:0] m_s [4][256];
    logic [31:0] m_p [18];
    bit          m_busy = 0;
    int          m_cnt  = 0;
    bit          m_done = 0;
    logic [63:0] m_out  = '0;
    logic [63:0] m_res  = '0;

    always #2.5 clk = ~clk;

    bfish_engine u_bfish_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dir_dec  (dir_dec),
        .blk_in   (blk_in),
        .wr_en    (wr_en),
        .wr_to_p  (wr_to_p),
        .wr_box   (wr_box),
        .wr_index (wr_index),
        .wr_data  (wr_data),
        .blk_out  (blk_out),
        .done     (done)
    );

    function automatic logic [31:0] ref_f(input logic [31:0] x);
        return ((m_s[0][x[31:24]] + m_s[1][x[23:16]]) ^ m_s[2][x[15:8]]) + m_s[3][x[7:0]];
    endfunction

    function automatic logic [63:0] ref_cipher(input logic [63:0] x, input bit dec);
        logic [31:0] l = x[63:32];
        logic [31:0] r = x[31:0];
        logic [31:0] t;
        for (int i = 0; i < 16; i++) begin
            l = l ^ m_p[dec ? 17 - i : i];
            r = r ^ ref_f(l);
            t = l; l = r; r = t;
        end
        t = l; l = r; r = t;
        r = r ^ m_p[dec ? 1 : 16];
        l = l ^ m_p[dec ? 0 : 17];
        return {l, r};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge from the sampled inputs
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_done = 0; m_out = '0;
        end else begin
            m_done = 0;
            if (wr_en && !m_busy && !start) begin
                if (wr_to_p) begin
                    if (wr_index < 8'd18) m_p[wr_index] = wr_data;
                end else begin
                    m_s[wr_box][wr_index] = wr_data;
                end
            end
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_cnt = 0;
                    m_res  = ref_cipher(blk_in, dir_dec);
                end
            end else begin
                m_cnt++;
                if (m_cnt == LATENCY) begin
                    m_busy = 0; m_done = 1; m_out = m_res;
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(done === m_done, "R6 R7 done timing", 64'(done), 64'(m_done));
            chk(blk_out === m_out, "R8 R1 output", blk_out, m_out);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(input bit to_p, input int box, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_to_p = to_p; wr_box = 2'(box); wr_index = 8'(idx); wr_data = d;
    endtask

    task automatic wr_end();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_tables(input bit rnd);
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 256; i++) begin
                logic [7:0] bi = 8'(i);
                wr(0, b, i, rnd ? $urandom : {bi ^ 8'(b), bi + 8'(b * 37), ~bi, 8'(i * 3 + b)});
            end
        end
        for (int k = 0; k < 18; k++) begin
            wr(1, 0, k, rnd ? $urandom : (32'h0101_0101 * k) ^ 32'hA5C3_0F00);
        end
        wr_end();
    endtask

    // Start one block and wait for done; returns the measured cycle count
    task automatic run_block(input logic [63:0] x, input bit dec, output logic [63:0] y, output int lat);
        @(negedge clk);
        start = 1'b1; dir_dec = dec; blk_in = x;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        y = blk_out;
    endtask

    initial begin
        logic [63:0] x, y, z, e, e2;
        int lat;

        repeat (5) @(negedge clk);
        chk(done === 1'b0, "R10 done after reset", 64'(done), 64'd0);
        chk(blk_out === 64'd0, "R10 output after reset", blk_out, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(blk_out === 64'd0 && done === 1'b0, "R10 idle after release", blk_out, 64'd0);

        // Structured tables
        load_tables(0);
        for (int v = 0; v < 3; v++) begin
            x = (v == 0) ? 64'd0 : (v == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0123_4567_89AB_CDEF;
            e = ref_cipher(x, 0);
            run_block(x, 0, y, lat);
            chk(y === e, "R1 R2 encrypt structured", y, e);
            chk(lat == LATENCY, "R6 latency", 64'(lat), 64'(LATENCY));
            @(negedge clk);
            chk(done === 1'b0, "R7 single pulse", 64'(done), 64'd0);
            run_block(y, 1, z, lat);
            chk(z === x, "R3 round trip", z, x);
        end

        // Random tables
        load_tables(1);
        for (int v = 0; v < 5; v++) begin
            x = {$urandom, $urandom};
            e = ref_cipher(x, 0);
            run_block(x, 0, y, lat);
            chk(y === e, "R1 R2 encrypt random", y, e);
            run_block(y, 1, z, lat);
            chk(z === x, "R3 decrypt returns plaintext", z, x);
            x = {$urandom, $urandom};
            e = ref_cipher(x, 1);
            run_block(x, 1, y, lat);
            chk(y === e, "R3 decrypt random", y, e);
        end

        // R8: output holds while idle and during the next block
        y = blk_out;
        repeat (6) @(negedge clk);
        chk(blk_out === y, "R8 hold while idle", blk_out, y);
        @(negedge clk);
        start = 1'b1; blk_in = 64'h1111_2222_3333_4444; dir_dec = 1'b0;
        e = ref_cipher(blk_in, 0);
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(blk_out === y, "R8 hold while busy", blk_out, y);
        while (!done) @(negedge clk);
        chk(blk_out === e, "R8 new result with done", blk_out, e);

        // R9: extra start while busy
        x = 64'hDEAD_BEEF_0BAD_F00D;
        e = ref_cipher(x, 0);
        @(negedge clk);
        start = 1'b1; blk_in = x; dir_dec = 1'b0;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (lat == 5 || lat == 33) begin
                start = 1'b1; blk_in = 64'h5555_AAAA_5555_AAAA; dir_dec = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(blk_out === e, "R9 result unchanged", blk_out, e);
        chk(lat == LATENCY, "R9 timing unchanged", 64'(lat), 64'(LATENCY));

        // R5: writes while busy and with the accepted start are ignored
        x = 64'h0F0F_1234_F0F0_5678;
        e = ref_cipher(x, 0);
        e2 = ref_cipher(64'h7777_0000_7777_0000, 0);
        @(negedge clk);
        start = 1'b1; blk_in = x; dir_dec = 1'b0;
        wr_en = 1'b1; wr_to_p = 1'b1; wr_index = 8'd17; wr_data = 32'hCAFE_0001;
        @(negedge clk);
        start = 1'b0;
        wr_index = 8'd0; wr_data = 32'hCAFE_0002;
        @(negedge clk);
        wr_to_p = 1'b0; wr_box = 2'd2; wr_index = x[47:40] ^ 8'h5A; wr_data = 32'hCAFE_0003;
        @(negedge clk);
        wr_to_p = 1'b1; wr_index = 8'd8; wr_data = 32'hCAFE_0004;
        @(negedge clk);
        wr_en = 1'b0;
        while (!done) @(negedge clk);
        chk(blk_out === e, "R5 busy writes ignored (current)", blk_out, e);
        run_block(64'h7777_0000_7777_0000, 0, y, lat);
        chk(y === e2, "R5 busy writes ignored (tables)", y, e2);

        // R4: out-of-range P index ignored, valid index takes effect
        x = 64'h2468_ACE0_1357_9BDF;
        e = ref_cipher(x, 0);
        wr(1, 0, 19, 32'h1357_2468);
        wr(1, 0, 200, 32'h0BAD_0BAD);
        wr_end();
        run_block(x, 0, y, lat);
        chk(y === e, "R4 index beyond P ignored", y, e);
        wr(1, 0, 5, 32'h8000_0001);
        wr(0, 3, 77, 32'h1234_5678);
        wr_end();
        e2 = ref_cipher(x, 0);
        run_block(x, 0, y, lat);
        chk(y === e2, "R4 P and S writes take effect", y, e2);
        chk(e2 !== e, "R4 write changed expected result", e2, e);
        run_block(y, 1, z, lat);
        chk(z === x, "R3 round trip after rewrite", z, x);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule